// File: doc/BRIEF.md
# Interrupt Hold-Off Countdown Controller

This block sits between the pending maskable interrupt requests of a processor core and its interrupt priority logic. When the core completes a "hold off interrupts for N cycles" instruction, the block masks every maskable request. The mask covers the cycle in which that instruction issues and the N instruction cycles that follow it. A down-counter holds the remaining window. The counter moves only on instruction cycles, so pipeline stalls do not shorten the window.

A new hold-off instruction can arrive while a window is already open. In that case the counter takes the new operand and the window runs from there. This also applies when the instruction lands on the exact cycle the previous window runs out: the window must open again and must not leak a single unmasked cycle. Lines that the build marks as non-maskable bypass the mask entirely.

Top module: `irq_holdoff`

## Requirements
- R1: While reset is asserted and after its release, the live count is 0 and the active flag is low until the first accepted issue strobe.
- R2: On a cycle where the issue strobe and the instruction-cycle enable are both high, the active flag is high and every maskable output line is 0 in that same cycle.
- R3: An accepted issue strobe loads the count operand N into the counter at the clock edge that ends the issue cycle. A strobe with N blocks maskable requests for N+1 instruction cycles in total.
- R4: On each enabled cycle without an issue strobe, a non-zero count decreases by exactly one. On cycles with the enable low, the count keeps its value.
- R5: An accepted issue strobe that arrives while the count is non-zero replaces the count with the new operand. Masking continues without a gap until the new count reaches zero.
- R6: An accepted issue strobe in the last masked cycle (count 1, about to reach 0) re-engages the hold-off with the new operand, with no unmasked cycle between the two windows. The same holds for a strobe in the first cycle where the count reads 0.
- R7: An operand of 0 masks only the issue cycle itself. The count stays 0 afterwards.
- R8: When the count is 0 and no accepted issue strobe is present, the active flag is low and each output line equals its request line.
- R9: Request lines whose bit is set in the parameter `NMI_MASK` are passed to the output unchanged in every cycle, whatever the count.
- R10: An issue strobe on a cycle with the enable low is ignored. It does not assert the active flag, does not load the counter, and does not mask any request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_en | input | 1 | Instruction-cycle enable; low during stalls |
| issue_vld | input | 1 | One-cycle strobe: hold-off instruction issuing |
| issue_cnt | input | CNT_W | Hold-off operand N |
| irq_req | input | NUM_IRQ | Pending interrupt requests |
| irq_out | output | NUM_IRQ | Requests after hold-off gating |
| hold_active | output | 1 | High while maskable requests are held off |
| hold_cnt | output | CNT_W | Live value of the countdown |

## Verification
The bench builds the block with a 4-bit counter, four request lines and the top line marked non-maskable. The narrow counter makes the largest operand (15) cheap to run down to zero. Within that short run, the bench can place reloads at count 2, at count 1 and at count 0, and can put stalls in the middle of a window. The non-maskable line is held high through open windows, which shows the bypass beside masked neighbours.

// File: rtl/hold_pkg.sv
package hold_pkg;

    // What the countdown does on a given clock edge.
    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_DEC   = 2'd2,
        ACT_STALL = 2'd3
    } hold_act_e;

endpackage

// File: rtl/hold_ctr.sv
module hold_ctr
    import hold_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_en,
    input  logic             issue_vld,
    input  logic [CNT_W-1:0] issue_cnt,
    output logic [CNT_W-1:0] cnt_o,
    output logic             hold_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_state_t;

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    ctr_state_t st_d, st_q;
    hold_act_e  act;
    logic       take_issue;
    logic       running;

    always_comb begin
        take_issue = issue_vld & cyc_en;
        running    = (st_q.cnt != CNT_ZERO);
        st_d       = st_q;
        if (!cyc_en)          act = ACT_STALL;
        else if (take_issue)  act = ACT_LOAD;
        else if (running)     act = ACT_DEC;
        else                  act = ACT_IDLE;
        case (act)
            ACT_LOAD: st_d.cnt = issue_cnt;
            ACT_DEC:  st_d.cnt = st_q.cnt - CNT_ONE;
            default:  st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign hold_o = take_issue | running;

    a_r2_issue_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && cyc_en) |-> hold_o);

    a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && cyc_en) |=> (cnt_o == $past(issue_cnt)));

    a_r4_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && !issue_vld && cnt_o != '0) |=> (cnt_o == CNT_W'($past(cnt_o) - 1'b1)));

    a_r4_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_en) |=> $stable(cnt_o));

    a_r10_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_en && cnt_o == '0) |-> !hold_o);

endmodule

// File: rtl/hold_gate.sv
module hold_gate #(
    parameter int                   NUM_IRQ  = 16,
    parameter logic [NUM_IRQ-1:0]   NMI_MASK = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold_i,
    input  logic [NUM_IRQ-1:0] irq_i,
    output logic [NUM_IRQ-1:0] irq_o
);

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        if (NMI_MASK[i]) begin : g_nmi
            assign irq_o[i] = irq_i[i];
        end else begin : g_mask
            assign irq_o[i] = irq_i[i] & ~hold_i;
        end
    end

    a_r8_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_i |-> (irq_o == irq_i));

    a_r9_nmi_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_o & NMI_MASK) == (irq_i & NMI_MASK)));

    a_r2_masked: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |-> ((irq_o & ~NMI_MASK) == '0));

endmodule

// File: rtl/irq_holdoff.sv
module irq_holdoff #(
    parameter int                 CNT_W    = 14,
    parameter int                 NUM_IRQ  = 16,
    parameter logic [NUM_IRQ-1:0] NMI_MASK = NUM_IRQ'(1) << (NUM_IRQ - 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cyc_en,
    input  logic               issue_vld,
    input  logic [CNT_W-1:0]   issue_cnt,
    input  logic [NUM_IRQ-1:0] irq_req,
    output logic [NUM_IRQ-1:0] irq_out,
    output logic               hold_active,
    output logic [CNT_W-1:0]   hold_cnt
);

    logic hold_w;

    hold_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_en    (cyc_en),
        .issue_vld (issue_vld),
        .issue_cnt (issue_cnt),
        .cnt_o     (hold_cnt),
        .hold_o    (hold_w)
    );

    hold_gate #(.NUM_IRQ(NUM_IRQ), .NMI_MASK(NMI_MASK)) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_i (hold_w),
        .irq_i  (irq_req),
        .irq_o  (irq_out)
    );

    assign hold_active = hold_w;

    // R6: a window ending at count 1 followed by an accepted strobe leaves no gap
    a_r6_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && !issue_vld && hold_cnt == CNT_W'(1)) ##1 (cyc_en && issue_vld) |-> hold_active);

    // R1
    a_r1_idle_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (hold_cnt == '0));

endmodule

// File: tb/test_irq_holdoff.sv
`timescale 1ns/1ps
module test_irq_holdoff;

    localparam int                 CW  = 4;
    localparam int                 NI  = 4;
    localparam logic [NI-1:0]      NMI = 4'b1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cyc_en = 1'b0;
    logic          issue_vld = 1'b0;
    logic [CW-1:0] issue_cnt = '0;
    logic [NI-1:0] irq_req = '0;
    logic [NI-1:0] irq_out;
    logic          hold_active;
    logic [CW-1:0] hold_cnt;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    irq_holdoff #(.CNT_W(CW), .NUM_IRQ(NI), .NMI_MASK(NMI)) i_irq_holdoff (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc_en      (cyc_en),
        .issue_vld   (issue_vld),
        .issue_cnt   (issue_cnt),
        .irq_req     (irq_req),
        .irq_out     (irq_out),
        .hold_active (hold_active),
        .hold_cnt    (hold_cnt)
    );

    typedef struct {
        logic          hold;
        logic [CW-1:0] cnt;
        logic [NI-1:0] irq;
        string         tag;
    } exp_t;

    exp_t          sb_q[$];
    logic [CW-1:0] m_cnt = '0;

    // Driver: applies one cycle of stimulus and pushes the outputs the requirements predict.
    task automatic step(input logic en, input logic iss, input logic [CW-1:0] n,
                        input logic [NI-1:0] req, input string tag);
        exp_t e;
        logic acc;
        @(negedge clk);
        cyc_en = en; issue_vld = iss; issue_cnt = n; irq_req = req;
        acc     = iss & en;
        e.hold  = acc | (m_cnt != '0);
        e.cnt   = m_cnt;
        e.irq   = e.hold ? (req & NMI) : req;
        e.tag   = tag;
        sb_q.push_back(e);
        if (acc)                     m_cnt = n;
        else if (en && m_cnt != '0)  m_cnt = m_cnt - 1'b1;
    endtask

    task automatic idle(input int k, input logic [NI-1:0] req, input string tag);
        for (int i = 0; i < k; i++) step(1'b1, 1'b0, '0, req, tag);
    endtask

    // Monitor: pops one expectation per cycle and compares after the driver has settled.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                total++;
                if (hold_active !== e.hold || hold_cnt !== e.cnt || irq_out !== e.irq) begin
                    bad++;
                    $display("FAIL %s: got hold=%b cnt=%0d irq=%b, expected hold=%b cnt=%0d irq=%b",
                             e.tag, hold_active, hold_cnt, irq_out, e.hold, e.cnt, e.irq);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got running, expected finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        total++;
        if (hold_cnt !== '0 || hold_active !== 1'b0) begin
            bad++;
            $display("FAIL R1 in reset: got cnt=%0d hold=%b, expected cnt=0 hold=0", hold_cnt, hold_active);
        end
        rst_n = 1'b1;
        idle(2, 4'b0111, "R1_R8 idle after reset");

        // R7: operand 0 masks the issue cycle only
        step(1'b1, 1'b1, 4'd0, 4'b1111, "R7_R2 issue n=0");
        idle(2, 4'b1111, "R7 after n=0");

        // R3: n=3 gives four masked cycles, the top line always passes (R9)
        step(1'b1, 1'b1, 4'd3, 4'b1011, "R3 issue n=3");
        idle(5, 4'b1011, "R3_R9 countdown");

        // R4: stalls inside a window keep the count
        step(1'b1, 1'b1, 4'd4, 4'b0101, "R4 issue n=4");
        step(1'b0, 1'b0, 4'd0, 4'b0101, "R4 stall");
        step(1'b0, 1'b0, 4'd0, 4'b0101, "R4 stall");
        idle(2, 4'b0101, "R4 run");
        step(1'b0, 1'b0, 4'd0, 4'b0101, "R4 stall");
        idle(4, 4'b0101, "R4 drain");

        // R5: reload at count 2
        step(1'b1, 1'b1, 4'd5, 4'b1111, "R5 issue n=5");
        idle(3, 4'b1111, "R5 run");
        step(1'b1, 1'b1, 4'd6, 4'b1111, "R5 reload at 2");
        idle(8, 4'b1111, "R5 drain");

        // R6: reload on the last masked cycle (count 1)
        step(1'b1, 1'b1, 4'd2, 4'b0110, "R6 issue n=2");
        idle(1, 4'b0110, "R6 run");
        step(1'b1, 1'b1, 4'd3, 4'b0110, "R6 reload at 1");
        idle(5, 4'b0110, "R6 drain");

        // R6: reload in the first cycle where the count reads 0
        step(1'b1, 1'b1, 4'd1, 4'b0011, "R6 issue n=1");
        idle(1, 4'b0011, "R6 run");
        step(1'b1, 1'b1, 4'd2, 4'b0011, "R6 reload at 0");
        idle(2, 4'b0011, "R6 second window");
        step(1'b1, 1'b1, 4'd1, 4'b0011, "R6 second reload");
        idle(3, 4'b0011, "R6 drain 2");

        // R10: strobe with the enable low is ignored
        step(1'b0, 1'b1, 4'd9, 4'b0111, "R10 strobe while stalled");
        idle(2, 4'b0111, "R10 no window");

        // R3: largest operand runs to zero
        step(1'b1, 1'b1, 4'd15, 4'b1110, "R3 issue n=15");
        idle(17, 4'b1110, "R3 max drain");

        // R8: varied patterns with no window
        step(1'b1, 1'b0, 4'd7, 4'b1010, "R8 pass");
        step(1'b1, 1'b0, 4'd7, 4'b0101, "R8 pass");
        step(1'b0, 1'b0, 4'd0, 4'b1111, "R8 pass stalled");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule